// File: doc/BRIEF.md
# Wait-Stalled Inbound Read Slave

This block is the target end of a parallel external bus. It serves read transfers of one word each. An external master starts a transfer by pulling an active-low select low while its read strobe is also low. The slave then registers the address and pulls its active-low wait output low, which holds the master off. It sends one request on an internal valid/ready port and waits for the matching response, which can take any number of cycles. When the word arrives, wait goes high again. The word and an even-parity bit are then driven on the bus until the master raises select.

The master sets the pace throughout. It may hold select low for as long as it likes after wait is released. It may start the next read in the cycle after the previous one ends, or leave idle cycles in between. The slave never samples the address bus during those idle cycles. If the master raises select while wait is still low, the transfer is abandoned: a request that has not yet been accepted is withdrawn, and a response that arrives later is dropped.

Top module: `wait_read_slave`

## Requirements
- R1: When the block is idle and samples select low with the read strobe low at a clock edge, wait_n is low in the next cycle and stays low until the block holds the read data.
- R2: In the cycle after such a start, req_valid_o is high and req_addr_o carries the address sampled at the start edge. It stays high until the first edge with req_ready_i high, and it then remains low for the rest of the transfer, so each transfer produces exactly one request.
- R3: A response (rsp_valid_i high) that is sampled while the current request is outstanding and select is low makes wait_n high, drive_o high and data_o equal to rsp_data_i in the next cycle. The response latency has no upper bound.
- R4: While drive_o is high and select stays low, data_o and par_o hold their values.
- R5: par_o is the even parity of the driven word, that is, the XOR of all data_o bits, so that the word and the parity bit together have an even number of ones.
- R6: Select sampled high ends any transfer. In the next cycle wait_n is high and drive_o is low, and a new transfer may start at the very next edge.
- R7: The address bus and read strobe are ignored whenever select is high, and also during the wait and data phases. None of these cycles raises req_valid_o.
- R8: Whenever drive_o is low, data_o and par_o are zero, which stands for the undriven bus.
- R9: If select goes high while wait_n is low, the block returns to idle. A request that was not yet accepted is withdrawn (req_valid_o low in the next cycle). A response to an abandoned request is discarded, even if it arrives during a later transfer, and it does not release wait.
- R10: Select low with the read strobe high while the block is idle does not start a transfer: wait_n stays high and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Slave select from the master, active low |
| rd_n | input | 1 | Read strobe from the master, active low |
| addr_i | input | ADDR_W | External address bus |
| wait_n | output | 1 | Wait to the master, active low |
| data_o | output | DATA_W | Read data; zero when not driven |
| par_o | output | 1 | Even parity of data_o; zero when not driven |
| drive_o | output | 1 | Output enable for data_o and par_o |
| req_valid_o | output | 1 | Internal read request valid |
| req_ready_i | input | 1 | Internal read request ready |
| req_addr_o | output | ADDR_W | Internal read request address |
| rsp_valid_i | input | 1 | Internal read response valid, one pulse per accepted request |
| rsp_data_i | input | DATA_W | Internal read response data |

## Verification
The assertions rely on four assumptions about the inputs. The internal side returns exactly one single-cycle response pulse for each accepted request, and it returns responses in request order. The master raises select only to end or abandon a transfer, and it never starts a transfer while reset is high. The bench keeps within these assumptions. Its memory model sends one response per handshake, after a random delay that in one case runs to several hundred cycles. Its abort case sends the response to the abandoned request only after the next request has been accepted. Between transfers it drives random address and strobe values, both in the gap cycles and while the block is waiting or driving data.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2
    } wrs_state_e;

    // Per-cycle control events shared between the sequencer and the request unit.
    typedef struct packed {
        logic start;  // read transfer begins this edge
        logic abort;  // select released while still waiting
        logic take;   // response belongs to the current transfer
    } wrs_ctl_t;

    function automatic logic even_par(input logic [63:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/wrs_fsm.sv
module wrs_fsm
    import wrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       rd_n,
    input  logic       rsp_take,
    output wrs_state_e state,
    output wrs_ctl_t   ctl
);
    wrs_state_e state_nx;

    always_comb begin
        ctl.start = (state == ST_IDLE) && !sel_n && !rd_n;
        ctl.abort = (state == ST_WAIT) && sel_n;
        ctl.take  = rsp_take;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ctl.start) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (sel_n)         state_nx = ST_IDLE;
                else if (rsp_take) state_nx = ST_DATA;
            end
            ST_DATA: if (sel_n) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end
endmodule

// File: rtl/wrs_req.sv
module wrs_req
    import wrs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DROP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  wrs_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              req_ready_i,
    input  logic              rsp_valid_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              rsp_take,
    output logic              waiting,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    logic pend;
    logic accepted;
    logic drop_dec;
    logic drop_inc;

    assign req_valid_o = pend;
    assign accepted    = pend && req_ready_i;
    assign drop_dec    = rsp_valid_i && (drop_cnt != '0);
    assign rsp_take    = rsp_valid_i && (drop_cnt == '0) && waiting;
    assign drop_inc    = ctl.abort && ((waiting && !rsp_take) || accepted);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            waiting    <= 1'b0;
            req_addr_o <= '0;
        end else begin
            if (ctl.start) begin
                pend       <= 1'b1;
                req_addr_o <= addr_i;
            end else if (ctl.abort || accepted) begin
                pend <= 1'b0;
            end

            if (ctl.abort)     waiting <= 1'b0;
            else if (accepted) waiting <= 1'b1;
            else if (rsp_take) waiting <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_cnt <= '0;
        end else if (drop_inc && !drop_dec) begin
            if (drop_cnt != DROP_MAX) drop_cnt <= drop_cnt + 1'b1;
        end else if (drop_dec && !drop_inc) begin
            drop_cnt <= drop_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wrs_dpath.sv
module wrs_dpath
    import wrs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              drive,
    output logic [DATA_W-1:0] data_o,
    output logic              par_o
);
    logic [DATA_W-1:0] word_q;
    logic              par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            par_q  <= 1'b0;
        end else if (load) begin
            word_q <= rsp_data_i;
            par_q  <= even_par(64'(rsp_data_i));
        end
    end

    assign data_o = drive ? word_q : '0;
    assign par_o  = drive ? par_q  : 1'b0;
endmodule

// File: rtl/wait_read_slave.sv
module wait_read_slave
    import wrs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DROP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              wait_n,
    output logic [DATA_W-1:0] data_o,
    output logic              par_o,
    output logic              drive_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i
);
    wrs_state_e        state;
    wrs_ctl_t          ctl;
    logic              rsp_take;
    logic              waiting;
    logic [DROP_W-1:0] drop_cnt;

    wrs_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .sel_n    (sel_n),
        .rd_n     (rd_n),
        .rsp_take (rsp_take),
        .state    (state),
        .ctl      (ctl)
    );

    wrs_req #(.ADDR_W(ADDR_W), .DROP_W(DROP_W)) i_req (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .addr_i      (addr_i),
        .req_ready_i (req_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .req_valid_o (req_valid_o),
        .req_addr_o  (req_addr_o),
        .rsp_take    (rsp_take),
        .waiting     (waiting),
        .drop_cnt    (drop_cnt)
    );

    wrs_dpath #(.DATA_W(DATA_W)) i_dpath (
        .clk        (clk),
        .rst        (rst),
        .load       (ctl.take && !ctl.abort),
        .rsp_data_i (rsp_data_i),
        .drive      (drive_o),
        .data_o     (data_o),
        .par_o      (par_o)
    );

    assign wait_n  = (state != ST_WAIT);
    assign drive_o = (state == ST_DATA);
endmodule

// File: rtl/wrs_chk.sv
module wrs_chk
    import wrs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DROP_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              rd_n,
    input logic              wait_n,
    input logic [DATA_W-1:0] data_o,
    input logic              par_o,
    input logic              drive_o,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic              rsp_valid_i,
    input logic [DATA_W-1:0] rsp_data_i,
    input wrs_state_e        state,
    input logic              waiting,
    input logic [DROP_W-1:0] drop_cnt
);
    // R1
    wait_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !sel_n && !rd_n) |=> !wait_n);

    // R10
    no_write_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (sel_n || rd_n)) |=> (wait_n && !req_valid_o));

    // R2
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_ready_i) |=> !req_valid_o);

    // R2
    req_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=> (!req_valid_o || $stable(req_addr_o)));

    // R3
    rsp_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !sel_n && rsp_valid_i && waiting && drop_cnt == '0)
        |=> (drive_o && wait_n && data_o == $past(rsp_data_i)));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_o && !sel_n) |=> (drive_o && $stable(data_o) && $stable(par_o)));

    // R5
    parity_chk: assert property (@(posedge clk) disable iff (rst)
        drive_o |-> (par_o == ^data_o));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> (wait_n && !drive_o));

    // R8
    undriven_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_o |-> (data_o == '0 && !par_o));

    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && sel_n) |=> !req_valid_o);
endmodule

bind wait_read_slave wrs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DROP_W(DROP_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_n       (sel_n),
    .rd_n        (rd_n),
    .wait_n      (wait_n),
    .data_o      (data_o),
    .par_o       (par_o),
    .drive_o     (drive_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .state       (state),
    .waiting     (waiting),
    .drop_cnt    (drop_cnt)
);

// File: tb/test_wait_read_slave.sv
module test_wait_read_slave;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1;
    logic          rd_n = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          wait_n;
    logic [DW-1:0] data_o;
    logic          par_o;
    logic          drive_o;
    logic          req_valid_o;
    logic          req_ready_i = 1'b0;
    logic [AW-1:0] req_addr_o;
    logic          rsp_valid_i = 1'b0;
    logic [DW-1:0] rsp_data_i = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wait_read_slave #(.ADDR_W(AW), .DATA_W(DW)) i_wait_read_slave (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rd_n(rd_n), .addr_i(addr_i),
        .wait_n(wait_n), .data_o(data_o), .par_o(par_o), .drive_o(drive_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic exp_par(input logic [DW-1:0] d);
        logic p = 1'b0;
        for (int i = 0; i < DW; i++) p = p ^ d[i];
        return p;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(wait_n == 1'b1, {tag, " wait_n"}, 64'(wait_n), 64'd1);
        chk(drive_o == 1'b0, {tag, " drive_o"}, 64'(drive_o), 64'd0);
        chk(data_o == '0 && par_o == 1'b0, {tag, " R8 undriven"}, {31'd0, par_o, data_o}, 64'd0);
        chk(req_valid_o == 1'b0, {tag, " req_valid"}, 64'(req_valid_o), 64'd0);
    endtask

    // One read transfer: gap cycles, start, request handshake, stale responses,
    // latency, response, hold, release.
    task automatic xfer(input logic [AW-1:0] a, input int gap, input int rdly,
                        input int lat, input int hold, input int stale);
        logic [DW-1:0] e;
        bit acc;
        int cnt;
        e = mem_word(a);
        for (int g = 0; g < gap; g++) begin
            sel_n = 1'b1; addr_i = AW'($urandom); rd_n = 1'($urandom);
            step();
            check_idle("R7 gap");
        end
        sel_n = 1'b0; rd_n = 1'b0; addr_i = a;
        step();
        chk(wait_n == 1'b0, "R1 wait after select", 64'(wait_n), 64'd0);
        chk(req_valid_o == 1'b1 && req_addr_o == a, "R2 request addr",
            {31'd0, req_valid_o, 16'd0, req_addr_o}, {32'd1, 16'd0, a});
        addr_i = AW'($urandom); rd_n = 1'($urandom);
        acc = 1'b0; cnt = 0;
        while (!acc) begin
            req_ready_i = (cnt >= rdly);
            if (req_valid_o && req_ready_i) acc = 1'b1;
            step();
            cnt++;
            chk(wait_n == 1'b0, "R1 wait held", 64'(wait_n), 64'd0);
        end
        req_ready_i = 1'b0;
        chk(req_valid_o == 1'b0, "R2 one request", 64'(req_valid_o), 64'd1 ^ 64'd1);
        for (int s = 0; s < stale; s++) begin
            rsp_valid_i = 1'b1; rsp_data_i = 32'hDEAD_BEEF;
            step();
            rsp_valid_i = 1'b0;
            chk(wait_n == 1'b0 && drive_o == 1'b0, "R9 stale response dropped",
                {wait_n, drive_o}, 64'd0);
        end
        for (int l = 0; l < lat; l++) begin
            req_ready_i = 1'($urandom); addr_i = AW'($urandom);
            step();
            chk(wait_n == 1'b0 && req_valid_o == 1'b0, "R3 R7 still waiting",
                {wait_n, req_valid_o}, 64'd0);
        end
        req_ready_i = 1'b0;
        rsp_valid_i = 1'b1; rsp_data_i = e;
        step();
        rsp_valid_i = 1'b0; rsp_data_i = DW'($urandom);
        chk(wait_n == 1'b1 && drive_o == 1'b1, "R3 release", {wait_n, drive_o}, 64'd3);
        chk(data_o == e, "R3 data", 64'(data_o), 64'(e));
        chk(par_o == exp_par(e), "R5 parity", 64'(par_o), 64'(exp_par(e)));
        for (int h = 0; h < hold; h++) begin
            addr_i = AW'($urandom); rd_n = 1'($urandom);
            step();
            chk(drive_o == 1'b1 && data_o == e && par_o == exp_par(e), "R4 hold",
                {31'd0, par_o, data_o}, {31'd0, exp_par(e), e});
        end
        sel_n = 1'b1;
        step();
        check_idle("R6 end");
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        chk(1'b0, "watchdog", 64'(cyc), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(); step();
        rst = 1'b0;
        check_idle("reset");

        // R10: select with write strobe does not start
        sel_n = 1'b0; rd_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            addr_i = AW'($urandom);
            step();
            check_idle("R10 write ignored");
        end
        sel_n = 1'b1;
        step();

        // directed: zero gap back to back, immediate ready, zero latency
        xfer(16'h0001, 0, 0, 0, 0, 0);
        xfer(16'hFFFF, 0, 0, 0, 3, 0);
        // long latency
        xfer(16'h1234, 2, 3, 300, 5, 0);

        // R9: abort before request accepted
        sel_n = 1'b0; rd_n = 1'b0; addr_i = 16'h0BAD;
        step();
        sel_n = 1'b1;
        step();
        check_idle("R9 abort before accept");

        // R9: abort after acceptance, stale response arrives in next transfer
        sel_n = 1'b0; rd_n = 1'b0; addr_i = 16'h0C0D;
        step();
        req_ready_i = 1'b1;
        step();
        req_ready_i = 1'b0;
        step();
        sel_n = 1'b1;
        step();
        check_idle("R9 abort after accept");
        xfer(16'h4321, 0, 1, 4, 2, 1);

        // constrained random transfers
        for (int n = 0; n < 40; n++) begin
            xfer(AW'($urandom), int'($urandom % 4), int'($urandom % 4),
                 int'($urandom % 25), int'($urandom % 5), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule